// File: doc/BRIEF.md
# UART Line-Break Detector with Receive Storage Interlock

This block watches a UART receiver for a line break and gates writes into the receive FIFO while a break is in progress. The deserializer hands it a one-cycle strobe for each finished character. The strobe carries the data byte, the received parity bit, the sampled stop-bit level and a framing-error flag. A character whose data, parity and stop bit are all zero starts a break. The block reports this with a one-cycle event pulse, which the status logic turns into a sticky, interrupt-raising bit.

While the break lasts, the line keeps producing null characters with framing errors. Only the first of them, the one that started the break, is written to the FIFO. All later ones are dropped. Other characters still pass through.

The raw receive pin goes through a two-flop synchronizer. A rising edge of the synchronized level, seen while a break is recorded, ends the break. This raises a second one-cycle event pulse and releases the storage interlock. The begin and end events strictly alternate.

Top module: `uart_brk_guard`

## Requirements
- R1: When `chr_valid_i` is high with `rx_en_i` high, no break recorded, `chr_data_i` all zero, and both `chr_parity_i` and `chr_stop_i` low, `brk_begin_o` is high for exactly the clock cycle after that strobe. The break is then recorded.
- R2: A strobe with any `chr_data_i` bit set, or with `chr_parity_i` high, or with `chr_stop_i` high, produces no `brk_begin_o` pulse.
- R3: While a break is recorded, a strobe with `chr_data_i` all zero and `chr_ferr_i` high drives `store_en_o` low in that same cycle. The strobe that began the break is itself stored.
- R4: `store_en_o` equals `chr_valid_i` in the strobe's own cycle for every other character while `rx_en_i` is high. This includes non-null characters and null characters without a framing error during a break.
- R5: `rx_pin_i` passes through two flops. If the synchronized level goes from 0 to 1 while a break is recorded, the break ends. If the pin is first seen at 1 at clock edge k (after being 0), `brk_end_o` is high for exactly the cycle after edge k+2.
- R6: A rising edge of the receive line while no break is recorded produces no `brk_end_o` pulse.
- R7: After a break ends, null characters with framing errors are stored again, and a new break can begin.
- R8: While a break is recorded, further null characters produce no new `brk_begin_o` pulse.
- R9: `brk_begin_o` and `brk_end_o` are never high in two consecutive cycles, and never high together.
- R10: Reset (`rst_ni` low) or `rx_en_i` low clears the break state, so that no pulse appears in the following cycle. `store_en_o` is low while `rx_en_i` is low.
- R11: If a null character with a framing error and a line rising edge are evaluated in the same cycle during a break, the break ends, the character is not stored, and no begin pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; low clears break state |
| chr_valid_i | input | 1 | One-cycle character-done strobe |
| chr_data_i | input | DATA_W | Received data bits |
| chr_parity_i | input | 1 | Received parity bit |
| chr_stop_i | input | 1 | Sampled stop-bit level |
| chr_ferr_i | input | 1 | Framing error on this character |
| rx_pin_i | input | 1 | Asynchronous receive pin |
| brk_begin_o | output | 1 | Break-begin event pulse |
| brk_end_o | output | 1 | Break-end event pulse |
| store_en_o | output | 1 | Write enable to the receive FIFO |

## Verification
The two functions that can coincide are the storage decision for a null character with a framing error and the end-of-break decision from a line rising edge. Both are evaluated against the same recorded break state in the same cycle. A directed case raises the pin exactly two clocks before such a character arrives. The bench then expects the character to be blocked, an end pulse to follow, and no begin pulse. Random stimulus with frequent null characters and slow pin toggling reaches the same overlap many more times, and a cycle model judges each occurrence.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic {
    BRK_IDLE = 1'b0,
    BRK_HELD = 1'b1
  } brk_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;  // idle line is high
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/chr_classify.sv
module chr_classify #(
  parameter int DATA_W = 8
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              parity_i,
  input  logic              stop_i,
  input  logic              ferr_i,
  output logic              is_null_o,
  output logic              zero_ferr_o
);
  logic data_zero;
  assign data_zero   = ~|data_i;
  assign is_null_o   = valid_i & data_zero & ~parity_i & ~stop_i;
  assign zero_ferr_o = valid_i & data_zero & ferr_i;
endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
  import brk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic is_null_i,
  input  logic rise_i,
  output logic held_o,
  output logic begin_o,
  output logic end_o
);
  brk_state_e state_q;
  logic beg_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BRK_IDLE;
      beg_q   <= 1'b0;
      end_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= BRK_IDLE;
      beg_q   <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      beg_q <= (state_q == BRK_IDLE) & is_null_i;
      end_q <= (state_q == BRK_HELD) & rise_i;
      unique case (state_q)
        BRK_IDLE: if (is_null_i) state_q <= BRK_HELD;
        BRK_HELD: if (rise_i)    state_q <= BRK_IDLE;
        default:                 state_q <= BRK_IDLE;
      endcase
    end
  end

  assign held_o  = (state_q == BRK_HELD);
  assign begin_o = beg_q;
  assign end_o   = end_q;
endmodule

// File: rtl/store_gate.sv
module store_gate (
  input  logic valid_i,
  input  logic en_i,
  input  logic held_i,
  input  logic zero_ferr_i,
  output logic store_o
);
  // in break, drop repeated null+ferr characters
  assign store_o = valid_i & en_i & ~(held_i & zero_ferr_i);
endmodule

// File: rtl/uart_brk_guard.sv
module uart_brk_guard #(
  parameter int DATA_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              chr_valid_i,
  input  logic [DATA_W-1:0] chr_data_i,
  input  logic              chr_parity_i,
  input  logic              chr_stop_i,
  input  logic              chr_ferr_i,
  input  logic              rx_pin_i,
  output logic              brk_begin_o,
  output logic              brk_end_o,
  output logic              store_en_o
);
  logic rise, is_null, zero_ferr, brk_held;

  rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (rx_pin_i),
    .rise_o (rise)
  );

  chr_classify #(.DATA_W(DATA_W)) u_cls (
    .valid_i     (chr_valid_i),
    .data_i      (chr_data_i),
    .parity_i    (chr_parity_i),
    .stop_i      (chr_stop_i),
    .ferr_i      (chr_ferr_i),
    .is_null_o   (is_null),
    .zero_ferr_o (zero_ferr)
  );

  brk_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en_i),
    .is_null_i (is_null),
    .rise_i    (rise),
    .held_o    (brk_held),
    .begin_o   (brk_begin_o),
    .end_o     (brk_end_o)
  );

  store_gate u_gate (
    .valid_i     (chr_valid_i),
    .en_i        (rx_en_i),
    .held_i      (brk_held),
    .zero_ferr_i (zero_ferr),
    .store_o     (store_en_o)
  );
endmodule

// File: rtl/uart_brk_guard_chk.sv
module uart_brk_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              chr_valid_i,
  input logic [DATA_W-1:0] chr_data_i,
  input logic              chr_ferr_i,
  input logic              brk_held,
  input logic              brk_begin_o,
  input logic              brk_end_o,
  input logic              store_en_o
);
  logic last_beg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_beg_q <= 1'b0;
    else if (!rx_en_i)    last_beg_q <= 1'b0;
    else if (brk_begin_o) last_beg_q <= 1'b1;
    else if (brk_end_o)   last_beg_q <= 1'b0;
  end

  p_block_null_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_valid_i && rx_en_i && brk_held && chr_data_i == '0 && chr_ferr_i) |-> !store_en_o);

  p_end_after_begin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_end_o |-> last_beg_q);

  p_begin_after_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_begin_o |-> !last_beg_q);

  p_begin_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_begin_o |=> !brk_begin_o);

  p_end_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_end_o |=> !brk_end_o);

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brk_begin_o && brk_end_o));

  p_off_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!brk_begin_o && !brk_end_o));

  p_off_nostore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> !store_en_o);
endmodule

bind uart_brk_guard uart_brk_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .chr_valid_i (chr_valid_i),
  .chr_data_i  (chr_data_i),
  .chr_ferr_i  (chr_ferr_i),
  .brk_held    (brk_held),
  .brk_begin_o (brk_begin_o),
  .brk_end_o   (brk_end_o),
  .store_en_o  (store_en_o)
);

// File: tb/uart_brk_guard_test.sv
module uart_brk_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1;
  logic valid = 1'b0;
  logic [7:0] data = 8'h00;
  logic par = 1'b0, stp = 1'b1, ferr = 1'b0, pin = 1'b1;
  logic brk_begin, brk_end, store_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_s3 = 1'b1;
  logic m_brk = 1'b0;

  always #2 clk = ~clk;

  uart_brk_guard #(.DATA_W(8), .SYNC_STGS(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .chr_valid_i(valid),
    .chr_data_i(data), .chr_parity_i(par), .chr_stop_i(stp), .chr_ferr_i(ferr),
    .rx_pin_i(pin), .brk_begin_o(brk_begin), .brk_end_o(brk_end),
    .store_en_o(store_en)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_store(input logic v, input logic en, input logic brk,
                                     input logic [7:0] d, input logic f);
    return v & en & ~(brk & (d == 8'h00) & f);
  endfunction

  function automatic logic is_null(input logic v, input logic [7:0] d, input logic p,
                                   input logic s);
    return v & (d == 8'h00) & ~p & ~s;
  endfunction

  // one clock: drive after negedge, check store, model edge, check pulses
  task automatic cyc(input logic v, input logic [7:0] d, input logic p, input logic s,
                     input logic f, input logic pn, input logic en, input string tag);
    logic rise, nul, eb, ee;
    valid = v; data = d; par = p; stp = s; ferr = f; pin = pn; rx_en = en;
    #1;
    chk(tag, "store_en", store_en, exp_store(v, en, m_brk, d, f));
    @(posedge clk);
    rise = m_s2 & ~m_s3;
    nul  = is_null(v, d, p, s);
    if (!en) begin
      eb = 1'b0; ee = 1'b0; m_brk = 1'b0;
    end else begin
      eb = nul & ~m_brk;
      ee = rise & m_brk;
      if (eb) m_brk = 1'b1;
      else if (ee) m_brk = 1'b0;
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pn;
    @(negedge clk);
    chk(tag, "brk_begin", brk_begin, eb);
    chk(tag, "brk_end", brk_end, ee);
  endtask

  task automatic idle(input int n, input logic pn, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h55, 1'b0, 1'b1, 1'b0, pn, 1'b1, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "reset begin", brk_begin, 1'b0);
    chk("R10", "reset end", brk_end, 1'b0);
    chk("R10", "reset store", store_en, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    idle(3, 1'b1, "R10");

    // R2 near-null characters do not begin
    cyc(1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R2");
    cyc(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R2");
    cyc(1'b1, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R2");
    idle(1, 1'b1, "R2");
    // R6 rising edge with no break
    idle(3, 1'b0, "R6");
    idle(4, 1'b1, "R6");
    // R1 break begins, first null is stored
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
    idle(1, 1'b0, "R9");
    // R8 / R3 repeated nulls blocked, no new begin
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
    // R4 other characters still stored in break
    cyc(1'b1, 8'h41, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
    cyc(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
    // R5 end of break on rising pin, R9 single-cycle
    idle(5, 1'b1, "R5");
    // R7 storage and begin re-enabled
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    idle(2, 1'b0, "R7");
    // R11 rise and null+ferr evaluated together
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R11");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R11");
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R11");
    idle(2, 1'b1, "R11");
    // R10 disable clears break
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R10");
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R10");
    idle(2, 1'b1, "R10");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic v, p, s, f, en;
      logic [7:0] d;
      string tag;
      v  = ($urandom % 3) == 0;
      d  = ($urandom % 2) ? 8'h00 : 8'($urandom);
      p  = ($urandom % 4) == 0;
      s  = ($urandom % 4) == 0;
      f  = $urandom % 2;
      en = ($urandom % 64) != 0;
      if (($urandom % 8) == 0) pin = ~pin;
      if (m_brk && v && d == 8'h00 && f) tag = "R3";
      else if (is_null(v, d, p, s)) tag = "R1";
      else tag = "R4";
      cyc(v, d, p, s, f, pin, en, tag);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule